// File: doc/BRIEF.md
# Host Bus Style Auto-Detector

This block sits behind the host pins of a peripheral and works out, after each hardware reset, which kind of microcontroller bus it is attached to. It settles two questions. The first is the control style: separate active-low read and write strobes, or a direction line with a single data strobe. The second is whether the address and data share pins (multiplexed) or A0 is a true address line (non-multiplexed). The two results drive mode flags that the bus decoder downstream uses to interpret host cycles.

The host firmware trains the block before its first real access to the device. It writes to external memory, then writes to and reads from an odd address. The block watches the synchronized pins during these cycles. When the first read that selects the device arrives, both answers are frozen until the next hardware reset. Until then the defaults apply: separate strobes and a multiplexed bus.

Pin roles: `hostRdN` is the read strobe in separate-strobe style and the data strobe in direction style. `hostWrN` is the write strobe in separate-strobe style and the direction line in direction style, where low means write and high means read.

Top module: `hbd_bus_detect`

## Requirements
- R1: While reset is asserted and right after it, `dirStrobeMode`=0, `busMuxed`=1 and `modeLocked`=0.
- R2: Before lock, a falling edge on `hostRdN` while `hostWrN` is low on both that sample and the one before sets `dirStrobeMode` to 1. The flag stays 1 until reset.
- R3: A write pulse on `hostWrN` while `hostRdN` stays high leaves `dirStrobeMode` at 0.
- R4: Before lock, any change of level on `hostA0`, rising or falling, clears `busMuxed` to 0. It stays 0 until reset.
- R5: If `hostA0` is held low through all host cycles, `busMuxed` stays 1.
- R6: Before lock, a read that selects the device sets `modeLocked` to 1, and it stays 1 until reset. Such a read is `hostCsN`=0 with `hostRdN`=0, and in direction style it also needs `hostWrN`=1. Each pin change is seen at the outputs on the third rising clock edge after it.
- R7: Once `modeLocked` is 1, neither `hostA0` activity nor direction-style write pulses change `dirStrobeMode` or `busMuxed`.
- R8: In direction style, a data-strobe pulse with `hostWrN` low (a write) while `hostCsN` is low does not set `modeLocked`.
- R9: In separate-strobe style, a write with `hostCsN` low and `hostRdN` high does not set `modeLocked`.
- R10: During the first SYNC_STAGES+1 cycles after reset is released, the block records no pin edges and no lock. Pin levels that were already present during reset therefore cause no mode change.
- R11: Asserting reset after lock returns all three outputs to the values given in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Hardware reset, active low, asynchronous |
| hostCsN | input | 1 | Chip select, active low |
| hostRdN | input | 1 | Read strobe, or data strobe in direction style |
| hostWrN | input | 1 | Write strobe, or direction line in direction style (low = write) |
| hostA0 | input | 1 | Lowest address pin |
| dirStrobeMode | output | 1 | 1 = direction plus data strobe, 0 = separate read/write strobes |
| busMuxed | output | 1 | 1 = multiplexed bus, 0 = non-multiplexed |
| modeLocked | output | 1 | 1 = both decisions are frozen |

## Verification
Every output reacts to a pin change on the third rising edge after it: two edges are spent in the synchronizer and one in the flag or state register. The bench holds each pin pattern for six cycles and samples on the falling edge at the end, well after the result is due. The directed tests that follow reset wait at least SYNC_STAGES+1 cycles before applying a new pin level. This lets the check for R10 tell apart an edge that was ignored during the priming window from one taken after it.

// File: rtl/hbd_pkg.sv
package hbd_pkg;

  typedef enum logic {
    ST_DETECT = 1'b0,
    ST_LOCKED = 1'b1
  } hbdState_t;

  // Observations from the datapath, already qualified by the priming window
  typedef struct packed {
    logic dsWrite;   // data strobe fell with direction held at write
    logic a0Edge;    // A0 changed level
    logic csAct;     // chip select active (and primed)
    logic rdLow;     // read / data strobe low
    logic dirRead;   // direction line at read level
  } hbdEvent_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic setDirStrobe;
    logic setNonMux;
  } hbdStrobe_t;

  localparam int PIN_CS = 3;
  localparam int PIN_RD = 2;
  localparam int PIN_WR = 1;
  localparam int PIN_A0 = 0;
  localparam int PIN_W  = 4;

endpackage

// File: rtl/hbd_sync.sv
module hbd_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain[0] <= RST_VAL;
    else       chain[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[s] <= RST_VAL;
      else       chain[s] <= chain[s-1];
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/hbd_datapath.sv
module hbd_datapath
  import hbd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PIN_W-1:0] pinsRaw,
  input  hbdStrobe_t       strobe,
  output hbdEvent_t        evt,
  output logic             dirStrobeQ,
  output logic             nonMuxQ
);

  localparam int PRIME_MAX = SYNC_STAGES + 1;
  localparam int CNT_W = $clog2(PRIME_MAX + 1);
  localparam logic [PIN_W-1:0] IDLE_PINS = 4'b1110;
  localparam logic [CNT_W-1:0] PRIME_END = CNT_W'(PRIME_MAX);

  logic [PIN_W-1:0] pinsCur;
  logic [PIN_W-1:0] pinsPrev;
  logic [CNT_W-1:0] primeCnt;
  logic             primed;

  hbd_sync #(
    .WIDTH  (PIN_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(IDLE_PINS)
  ) i_sync (
    .clk (clk),
    .rstN(rstN),
    .din (pinsRaw),
    .dout(pinsCur)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinsPrev <= IDLE_PINS;
      primeCnt <= '0;
    end else begin
      pinsPrev <= pinsCur;
      if (primeCnt != PRIME_END) primeCnt <= primeCnt + 1'b1;
    end
  end

  assign primed = (primeCnt == PRIME_END);

  always_comb begin
    evt.dsWrite = primed && pinsPrev[PIN_RD] && !pinsCur[PIN_RD]
                  && !pinsPrev[PIN_WR] && !pinsCur[PIN_WR];
    evt.a0Edge  = primed && (pinsPrev[PIN_A0] != pinsCur[PIN_A0]);
    evt.csAct   = primed && !pinsCur[PIN_CS];
    evt.rdLow   = !pinsCur[PIN_RD];
    evt.dirRead = pinsCur[PIN_WR];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirStrobeQ <= 1'b0;
      nonMuxQ    <= 1'b0;
    end else begin
      if (strobe.setDirStrobe) dirStrobeQ <= 1'b1;
      if (strobe.setNonMux)    nonMuxQ    <= 1'b1;
    end
  end

endmodule

// File: rtl/hbd_control.sv
module hbd_control
  import hbd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  hbdEvent_t  evt,
  input  logic       dirStrobeQ,
  output hbdStrobe_t strobe,
  output logic       lockedQ
);

  hbdState_t state;
  hbdState_t stateNxt;
  logic      detecting;
  logic      readAccess;

  assign detecting  = (state == ST_DETECT);
  assign readAccess = evt.csAct && evt.rdLow && (!dirStrobeQ || evt.dirRead);

  always_comb begin
    stateNxt = state;
    if (detecting && readAccess) stateNxt = ST_LOCKED;
  end

  always_comb begin
    strobe.setDirStrobe = detecting && evt.dsWrite;
    strobe.setNonMux    = detecting && evt.a0Edge;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_DETECT;
    else       state <= stateNxt;
  end

  assign lockedQ = (state == ST_LOCKED);

endmodule

// File: rtl/hbd_bus_detect.sv
module hbd_bus_detect
  import hbd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic hostCsN,
  input  logic hostRdN,
  input  logic hostWrN,
  input  logic hostA0,
  output logic dirStrobeMode,
  output logic busMuxed,
  output logic modeLocked
);

  hbdEvent_t  evt;
  hbdStrobe_t strobe;
  logic       dirStrobeQ;
  logic       nonMuxQ;
  logic [PIN_W-1:0] pinsRaw;

  assign pinsRaw = {hostCsN, hostRdN, hostWrN, hostA0};

  hbd_datapath #(.SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .pinsRaw   (pinsRaw),
    .strobe    (strobe),
    .evt       (evt),
    .dirStrobeQ(dirStrobeQ),
    .nonMuxQ   (nonMuxQ)
  );

  hbd_control i_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .evt       (evt),
    .dirStrobeQ(dirStrobeQ),
    .strobe    (strobe),
    .lockedQ   (modeLocked)
  );

  assign dirStrobeMode = dirStrobeQ;
  assign busMuxed      = !nonMuxQ;

endmodule

// File: rtl/hbd_checker.sv
module hbd_checker (
  input logic clk,
  input logic rstN,
  input logic hostCsN,
  input logic dirStrobeMode,
  input logic busMuxed,
  input logic modeLocked
);

  // R7
  frozen_after_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeLocked |=> ($stable(dirStrobeMode) && $stable(busMuxed)));

  // R6
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeLocked |=> modeLocked);

  // R6
  lock_needs_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modeLocked) |-> !$past(hostCsN, 3));

  // R2
  dir_style_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    dirStrobeMode |=> dirStrobeMode);

  // R4
  nonmux_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busMuxed |=> !busMuxed);

endmodule

bind hbd_bus_detect hbd_checker i_chk (.*);

// File: tb/test_hbd_bus_detect.sv
module test_hbd_bus_detect;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostCsN = 1'b1, hostRdN = 1'b1, hostWrN = 1'b1, hostA0 = 1'b0;
  logic dirStrobeMode, busMuxed, modeLocked;

  int nChecks = 0;
  int nFails = 0;

  always #4 clk = ~clk;

  hbd_bus_detect i_hbd_bus_detect (
    .clk(clk), .rstN(rstN), .hostCsN(hostCsN), .hostRdN(hostRdN),
    .hostWrN(hostWrN), .hostA0(hostA0), .dirStrobeMode(dirStrobeMode),
    .busMuxed(busMuxed), .modeLocked(modeLocked)
  );

  // {req[3:0], cs, rd, wr, a0, expDs, expMux, expLock}
  localparam int NVEC = 12;
  localparam logic [10:0] VEC [NVEC] = '{
    {4'd1, 4'b1110, 3'b010},  // R1 idle after reset
    {4'd3, 4'b1100, 3'b010},  // R3 write strobe low
    {4'd3, 4'b1110, 3'b010},  // R3 write strobe released
    {4'd4, 4'b1111, 3'b000},  // R4 A0 rises
    {4'd9, 4'b0101, 3'b000},  // R9 selected write, no lock
    {4'd9, 4'b1111, 3'b000},  // R9 idle
    {4'd6, 4'b0011, 3'b001},  // R6 selected read locks
    {4'd6, 4'b1111, 3'b001},  // R6 lock held
    {4'd7, 4'b1110, 3'b001},  // R7 A0 falls after lock
    {4'd7, 4'b1100, 3'b001},  // R7 direction low after lock
    {4'd7, 4'b1000, 3'b001},  // R7 data strobe pulse ignored
    {4'd7, 4'b1110, 3'b001}   // R7 idle
  };

  task automatic check(input int req, input string what, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL R%0d %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic checkAll(input int req, input logic eDs, input logic eMux, input logic eLock);
    check(req, "dirStrobeMode", dirStrobeMode, eDs);
    check(req, "busMuxed", busMuxed, eMux);
    check(req, "modeLocked", modeLocked, eLock);
  endtask

  task automatic applyPins(input logic [3:0] p, input int cycles);
    @(negedge clk);
    {hostCsN, hostRdN, hostWrN, hostA0} = p;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic doReset(input logic [3:0] p);
    @(negedge clk);
    rstN = 1'b0;
    {hostCsN, hostRdN, hostWrN, hostA0} = p;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #200000;
    nFails++;
    nChecks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checkAll(1, 1'b0, 1'b1, 1'b0);  // R1 during reset
    rstN = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      applyPins(VEC[v][6:3], 6);
      checkAll(int'(VEC[v][10:7]), VEC[v][2], VEC[v][1], VEC[v][0]);
    end

    // R11: reset after lock restores defaults
    doReset(4'b1110);
    repeat (6) @(negedge clk);
    checkAll(11, 1'b0, 1'b1, 1'b0);

    // R2: direction-style write, then R8, R5, R6
    applyPins(4'b1100, 6);
    checkAll(2, 1'b0, 1'b1, 1'b0);
    applyPins(4'b1000, 6);
    checkAll(2, 1'b1, 1'b1, 1'b0);  // R2 data strobe with direction low
    applyPins(4'b1100, 6);
    applyPins(4'b1110, 6);
    checkAll(2, 1'b1, 1'b1, 1'b0);
    applyPins(4'b0100, 6);
    applyPins(4'b0000, 6);
    checkAll(8, 1'b1, 1'b1, 1'b0);  // R8 selected write, direction style
    applyPins(4'b0100, 6);
    applyPins(4'b0110, 6);
    checkAll(5, 1'b1, 1'b1, 1'b0);  // R5 A0 kept low
    applyPins(4'b0010, 6);
    checkAll(6, 1'b1, 1'b1, 1'b1);  // R6 direction-style read locks
    applyPins(4'b1110, 6);
    checkAll(5, 1'b1, 1'b1, 1'b1);

    // R10: pin levels present during reset are not taken as edges
    doReset(4'b1001);
    repeat (6) @(negedge clk);
    checkAll(10, 1'b0, 1'b1, 1'b0);
    applyPins(4'b1110, 6);
    checkAll(10, 1'b0, 1'b0, 1'b0);  // later A0 edge still counts (R4)

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule